// File: doc/BRIEF.md
# Predicted-Invalidation Responder with Invalidated-Lines Table

This block sits at a sharer node of a directory-based coherent multiprocessor. When a requester guesses the set of sharers of a line on an upgrade miss, it sends each guessed sharer an invalidation flagged as predicted, in parallel with its request to the home directory. The responder decides, from the local line state and the miss status of that line, whether to accept the invalidation (ACK, with a command to invalidate the local copy) or to refuse it (NACK). An invalidation that hits a line with a load miss in flight is refused. The miss handler is told to keep it, so the fill can be dropped later.

Lines that are invalidated from a plain Shared state are recorded in a small fully associative Invalidated-Lines Table (ILT). When the node later issues a load miss, the miss is passed through with a one-bit flag. The flag is set when the line's tag is in the table, so the directory can hold that load until the upgrade that took the line away has completed. A hit removes the entry. When the table is full, new tags replace entries in round-robin order. The cache arrays, the miss handler and the network are outside the block. The line state and the miss status for the invalidated tag arrive on the same cycle as the invalidation.

Top module: `pinv_responder`

## Requirements
- R1: A predicted invalidation to a line with a pending load miss gets a NACK with `rsp_keep`=1 and no invalidate command. This case has priority over all others.
- R2: With an upgrade miss pending, no directory reply yet and the line in Shared (`line_state`=2'b01), the response is an ACK with an invalidate command, and the tag is not added to the ILT.
- R3: With an upgrade miss pending and its directory reply already received, the response is a NACK with no invalidate. The same holds for a pending upgrade whose line is not Shared.
- R4: With no pending miss and the line Shared, the response is an ACK with an invalidate command, and the tag is inserted into the ILT.
- R5: With no pending miss and the line Invalid (2'b00), Exclusive (2'b10) or Modified (2'b11), the response is a NACK with no invalidate and no ILT change.
- R6: Each accepted invalidation gives exactly one response, one cycle later, and the response echoes the tag. `inv_valid`/`inv_tag` appear in that same cycle. No response appears in a cycle that follows a cycle without a request. `rsp_keep` is 1 only in the R1 case.
- R7: A load miss is forwarded one cycle after it is accepted, with its tag. `ldm_out_invbit`=1 exactly when the tag was in the ILT at acceptance.
- R8: A load miss that hits the ILT removes that entry, so the next load miss to the same tag carries `ldm_out_invbit`=0.
- R9: New tags take the lowest-numbered free entry. When the table is full, they replace entries in round-robin order starting at entry 0, and the pointer advances only on such a replacement.
- R10: Inserting a tag that is already present does not create a second entry. If a load miss and an insert of the same tag land in the same cycle, the load miss sees the table as it was before that cycle and the entry stays valid.
- R11: During and after reset all outputs are 0 and the ILT is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pinv_valid | input | 1 | Predicted invalidation present |
| pinv_tag | input | TAG_W | Line tag of the invalidation |
| line_state | input | 2 | Local state of that line: 00 I, 01 S, 10 E, 11 M |
| pend_load | input | 1 | A load miss to that line is pending |
| pend_upg | input | 1 | An upgrade miss to that line is pending |
| upg_replied | input | 1 | Directory reply to that upgrade already received |
| ldm_valid | input | 1 | Local load miss being issued |
| ldm_tag | input | TAG_W | Tag of the load miss |
| rsp_valid | output | 1 | Response to a predicted invalidation |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rsp_keep | output | 1 | Invalidation must be held by the pending load miss |
| rsp_tag | output | TAG_W | Tag the response refers to |
| inv_valid | output | 1 | Invalidate the local copy |
| inv_tag | output | TAG_W | Tag to invalidate |
| ldm_out_valid | output | 1 | Load miss forwarded to the network |
| ldm_out_tag | output | TAG_W | Its tag |
| ldm_out_invbit | output | 1 | Line was invalidated by a predicted invalidation |

## Verification
Every result of this block is due exactly one clock after the request is sampled. This covers the response, the invalidate command and the forwarded load miss with its flag. An ILT insert or removal is visible to a load miss accepted on the following cycle. The bench drives inputs on the falling edge, records the expected outputs for that request in a reference model, and compares them at the next falling edge, one rising edge later. Directed sequences cover each decision case, table fill and round-robin victim order, duplicate inserts and same-cycle insert/lookup of one tag.

// File: rtl/pinv_pkg.sv
// Package: shared types of the predicted-invalidation responder.
// Assumes line states are encoded in two bits as listed below.
package pinv_pkg;

    typedef enum logic [1:0] {
        LS_INVALID   = 2'b00,
        LS_SHARED    = 2'b01,
        LS_EXCLUSIVE = 2'b10,
        LS_MODIFIED  = 2'b11
    } line_st_e;

    typedef enum logic [2:0] {
        WHY_NONE,
        WHY_LOAD_PEND,
        WHY_UPG_EARLY,
        WHY_UPG_LATE,
        WHY_SHARED_IDLE,
        WHY_OTHER
    } verdict_why_e;

    typedef struct packed {
        logic         ack;
        logic         keep;
        logic         inval;
        logic         ilt_ins;
        verdict_why_e why;
    } verdict_t;

endpackage

// File: rtl/pinv_decide.sv
// Module: pinv_decide
// Combinational decision for one predicted invalidation.
// Assumes the line state and the miss flags refer to the invalidated tag
// and are valid in the same cycle as req_valid. Priority: pending load,
// then pending upgrade, then line state.
module pinv_decide
    import pinv_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] state_raw,
    input  logic       pend_load,
    input  logic       pend_upg,
    input  logic       upg_replied,
    output verdict_t   verdict
);

    line_st_e state;

    // Decode the raw state bits into the enum.
    always_comb state = line_st_e'(state_raw);

    // Choose ACK/NACK and the side effects.
    always_comb begin
        verdict = '{ack: 1'b0, keep: 1'b0, inval: 1'b0, ilt_ins: 1'b0, why: WHY_NONE};
        if (req_valid) begin
            if (pend_load) begin
                verdict.keep = 1'b1;
                verdict.why  = WHY_LOAD_PEND;
            end else if (pend_upg) begin
                if (!upg_replied && state == LS_SHARED) begin
                    verdict.ack   = 1'b1;
                    verdict.inval = 1'b1;
                    verdict.why   = WHY_UPG_EARLY;
                end else begin
                    verdict.why   = WHY_UPG_LATE;
                end
            end else if (state == LS_SHARED) begin
                verdict.ack     = 1'b1;
                verdict.inval   = 1'b1;
                verdict.ilt_ins = 1'b1;
                verdict.why     = WHY_SHARED_IDLE;
            end else begin
                verdict.why = WHY_OTHER;
            end
        end
    end

endmodule

// File: rtl/pinv_ilt.sv
// Module: pinv_ilt
// Fully associative table of invalidated line tags.
// A lookup reports whether its tag is present and removes the matching
// entry at the clock edge. An insert reuses a matching entry, otherwise it
// takes the lowest free entry, otherwise the round-robin victim. The insert
// is applied after the removal, so a same-tag pair leaves the entry valid.
// Assumes the same tag is never held twice (guaranteed by the insert rule).
module pinv_ilt #(
    parameter int TAG_W = 20,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             look_valid,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [DEPTH-1:0]       ent_vld;
    logic [TAG_W-1:0]       ent_tag [DEPTH];
    logic [IDX_W-1:0]       rr_ptr;

    logic [DEPTH-1:0]       look_match;
    logic [DEPTH-1:0]       ins_match;
    logic [DEPTH-1:0]       clr_mask;
    logic [DEPTH-1:0]       set_mask;
    logic                   ins_dup;
    logic                   any_free;
    logic [IDX_W-1:0]       dup_idx;
    logic [IDX_W-1:0]       free_idx;
    logic [IDX_W-1:0]       ins_idx;
    logic                   use_victim;

    // Per-entry comparators for the lookup and the insert.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign look_match[g] = ent_vld[g] && (ent_tag[g] == look_tag);
        assign ins_match[g]  = ent_vld[g] && (ent_tag[g] == ins_tag);
    end

    // Hit result of the lookup against the current contents.
    always_comb look_hit = look_valid && (|look_match);

    // Find a duplicate entry and the lowest free entry.
    always_comb begin
        ins_dup  = 1'b0;
        any_free = 1'b0;
        dup_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ins_match[i]) begin
                ins_dup = 1'b1;
                dup_idx = IDX_W'(i);
            end
            if (!ent_vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Select the slot written by an insert.
    always_comb begin
        use_victim = 1'b0;
        if (ins_dup) begin
            ins_idx = dup_idx;
        end else if (any_free) begin
            ins_idx = free_idx;
        end else begin
            ins_idx    = rr_ptr;
            use_victim = ins_valid;
        end
    end

    // Build clear and set masks for this cycle.
    always_comb begin
        clr_mask = look_valid ? look_match : '0;
        set_mask = '0;
        if (ins_valid) set_mask[ins_idx] = 1'b1;
    end

    // Valid bits: remove the looked-up entry, then apply the insert.
    always_ff @(posedge clk) begin
        if (!rst_n) ent_vld <= '0;
        else        ent_vld <= (ent_vld & ~clr_mask) | set_mask;
    end

    // Tag storage written on insert.
    always_ff @(posedge clk) begin
        if (ins_valid) ent_tag[ins_idx] <= ins_tag;
    end

    // Round-robin victim pointer, advanced only on a replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)          rr_ptr <= '0;
        else if (use_victim) rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
    end

endmodule

// File: rtl/pinv_resp_reg.sv
// Module: pinv_resp_reg
// Output register stage for the invalidation response and invalidate command.
// Assumes one request per cycle; every request yields one registered response.
module pinv_resp_reg
    import pinv_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  verdict_t         verdict,
    output logic             rsp_valid,
    output logic             rsp_ack,
    output logic             rsp_keep,
    output logic [TAG_W-1:0] rsp_tag,
    output logic             inv_valid,
    output logic [TAG_W-1:0] inv_tag
);

    // Register the response fields one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
            rsp_keep  <= 1'b0;
            rsp_tag   <= '0;
            inv_valid <= 1'b0;
            inv_tag   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ack   <= req_valid && verdict.ack;
            rsp_keep  <= req_valid && verdict.keep;
            rsp_tag   <= req_valid ? req_tag : '0;
            inv_valid <= req_valid && verdict.inval;
            inv_tag   <= (req_valid && verdict.inval) ? req_tag : '0;
        end
    end

endmodule

// File: rtl/pinv_responder.sv
// Module: pinv_responder (top)
// Answers predicted invalidations with ACK/NACK, issues the invalidate
// command, records idle-Shared invalidations in the ILT and flags outgoing
// load misses whose line is in the ILT. All outputs are registered once.
// Assumes the cache supplies the line state and miss flags combinationally.
module pinv_responder #(
    parameter int TAG_W     = 20,
    parameter int ILT_DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pinv_valid,
    input  logic [TAG_W-1:0] pinv_tag,
    input  logic [1:0]       line_state,
    input  logic             pend_load,
    input  logic             pend_upg,
    input  logic             upg_replied,
    input  logic             ldm_valid,
    input  logic [TAG_W-1:0] ldm_tag,
    output logic             rsp_valid,
    output logic             rsp_ack,
    output logic             rsp_keep,
    output logic [TAG_W-1:0] rsp_tag,
    output logic             inv_valid,
    output logic [TAG_W-1:0] inv_tag,
    output logic             ldm_out_valid,
    output logic [TAG_W-1:0] ldm_out_tag,
    output logic             ldm_out_invbit
);

    import pinv_pkg::*;

    verdict_t verdict;
    logic     ilt_hit;

    pinv_decide u_decide (
        .req_valid   (pinv_valid),
        .state_raw   (line_state),
        .pend_load   (pend_load),
        .pend_upg    (pend_upg),
        .upg_replied (upg_replied),
        .verdict     (verdict)
    );

    pinv_ilt #(.TAG_W(TAG_W), .DEPTH(ILT_DEPTH)) u_ilt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_valid  (verdict.ilt_ins),
        .ins_tag    (pinv_tag),
        .look_valid (ldm_valid),
        .look_tag   (ldm_tag),
        .look_hit   (ilt_hit)
    );

    pinv_resp_reg #(.TAG_W(TAG_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (pinv_valid),
        .req_tag   (pinv_tag),
        .verdict   (verdict),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack),
        .rsp_keep  (rsp_keep),
        .rsp_tag   (rsp_tag),
        .inv_valid (inv_valid),
        .inv_tag   (inv_tag)
    );

    // Forward the load miss with the invalidated flag one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldm_out_valid  <= 1'b0;
            ldm_out_tag    <= '0;
            ldm_out_invbit <= 1'b0;
        end else begin
            ldm_out_valid  <= ldm_valid;
            ldm_out_tag    <= ldm_valid ? ldm_tag : '0;
            ldm_out_invbit <= ilt_hit;
        end
    end

endmodule

// File: rtl/pinv_responder_chk.sv
// Module: pinv_responder_chk
// Port-level properties of pinv_responder, attached with bind.
module pinv_responder_chk #(
    parameter int TAG_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pinv_valid,
    input logic [TAG_W-1:0] pinv_tag,
    input logic [1:0]       line_state,
    input logic             pend_load,
    input logic             pend_upg,
    input logic             upg_replied,
    input logic             ldm_valid,
    input logic [TAG_W-1:0] ldm_tag,
    input logic             rsp_valid,
    input logic             rsp_ack,
    input logic             rsp_keep,
    input logic [TAG_W-1:0] rsp_tag,
    input logic             inv_valid,
    input logic [TAG_W-1:0] inv_tag,
    input logic             ldm_out_valid,
    input logic [TAG_W-1:0] ldm_out_tag,
    input logic             ldm_out_invbit
);

    AST_LOAD_PEND_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        pinv_valid && pend_load |=> rsp_valid && !rsp_ack && rsp_keep && !inv_valid); // R1

    AST_UPG_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pinv_valid && !pend_load && pend_upg && !upg_replied && line_state == 2'b01
        |=> rsp_ack && inv_valid && inv_tag == $past(pinv_tag)); // R2

    AST_UPG_LATE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        pinv_valid && !pend_load && pend_upg && upg_replied |=> !rsp_ack && !inv_valid); // R3

    AST_IDLE_OTHER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        pinv_valid && !pend_load && !pend_upg && line_state != 2'b01 |=> !rsp_ack && !inv_valid); // R5

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        pinv_valid |=> rsp_valid && rsp_tag == $past(pinv_tag)); // R6

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !pinv_valid |=> !rsp_valid && !inv_valid); // R6

    AST_LDM_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        ldm_valid |=> ldm_out_valid && ldm_out_tag == $past(ldm_tag)); // R7

    AST_INVBIT_NEEDS_LDM: assert property (@(posedge clk) disable iff (!rst_n)
        !ldm_valid |=> !ldm_out_invbit && !ldm_out_valid); // R7

endmodule

bind pinv_responder pinv_responder_chk #(.TAG_W(TAG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pinv_valid     (pinv_valid),
    .pinv_tag       (pinv_tag),
    .line_state     (line_state),
    .pend_load      (pend_load),
    .pend_upg       (pend_upg),
    .upg_replied    (upg_replied),
    .ldm_valid      (ldm_valid),
    .ldm_tag        (ldm_tag),
    .rsp_valid      (rsp_valid),
    .rsp_ack        (rsp_ack),
    .rsp_keep       (rsp_keep),
    .rsp_tag        (rsp_tag),
    .inv_valid      (inv_valid),
    .inv_tag        (inv_tag),
    .ldm_out_valid  (ldm_out_valid),
    .ldm_out_tag    (ldm_out_tag),
    .ldm_out_invbit (ldm_out_invbit)
);

// File: tb/pinv_responder_tb_top.sv
// Bench: directed cases plus seeded random traffic against a reference model.
module pinv_responder_tb_top;

    localparam int TW = 12;
    localparam int ND = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pinv_valid = 1'b0;
    logic [TW-1:0] pinv_tag = '0;
    logic [1:0]    line_state = 2'b00;
    logic          pend_load = 1'b0, pend_upg = 1'b0, upg_replied = 1'b0;
    logic          ldm_valid = 1'b0;
    logic [TW-1:0] ldm_tag = '0;
    logic          rsp_valid, rsp_ack, rsp_keep, inv_valid;
    logic [TW-1:0] rsp_tag, inv_tag, ldm_out_tag;
    logic          ldm_out_valid, ldm_out_invbit;

    always #4 clk = ~clk;

    pinv_responder #(.TAG_W(TW), .ILT_DEPTH(ND)) dut_i (
        .clk(clk), .rst_n(rst_n), .pinv_valid(pinv_valid), .pinv_tag(pinv_tag),
        .line_state(line_state), .pend_load(pend_load), .pend_upg(pend_upg),
        .upg_replied(upg_replied), .ldm_valid(ldm_valid), .ldm_tag(ldm_tag),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_keep(rsp_keep),
        .rsp_tag(rsp_tag), .inv_valid(inv_valid), .inv_tag(inv_tag),
        .ldm_out_valid(ldm_out_valid), .ldm_out_tag(ldm_out_tag),
        .ldm_out_invbit(ldm_out_invbit)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference ILT
    bit          m_vld [ND];
    logic [TW-1:0] m_tag [ND];
    int          m_ptr;

    // expected outputs for the pending request
    bit          e_rv, e_ack, e_keep, e_iv, e_lv, e_lb;
    logic [TW-1:0] e_rt, e_it, e_lt;
    string       e_req, e_lreq;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [TW-1:0] t);
        for (int i = 0; i < ND; i++) if (m_vld[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < ND; i++) begin m_vld[i] = 0; m_tag[i] = '0; end
        m_ptr = 0;
        {e_rv, e_ack, e_keep, e_iv, e_lv, e_lb} = '0;
        e_rt = '0; e_it = '0; e_lt = '0; e_req = "R11"; e_lreq = "R11";
    endtask

    task automatic compare();
        chk(rsp_valid == e_rv, "R6", "rsp_valid", rsp_valid, e_rv);
        chk(rsp_ack == e_ack, e_req, "rsp_ack", rsp_ack, e_ack);
        chk(rsp_keep == e_keep, e_req, "rsp_keep", rsp_keep, e_keep);
        chk(inv_valid == e_iv, e_req, "inv_valid", inv_valid, e_iv);
        if (e_rv) chk(rsp_tag == e_rt, "R6", "rsp_tag", rsp_tag, e_rt);
        if (e_iv) chk(inv_tag == e_it, "R6", "inv_tag", inv_tag, e_it);
        chk(ldm_out_valid == e_lv, "R7", "ldm_out_valid", ldm_out_valid, e_lv);
        if (e_lv) chk(ldm_out_tag == e_lt, "R7", "ldm_out_tag", ldm_out_tag, e_lt);
        chk(ldm_out_invbit == e_lb, e_lreq, "ldm_out_invbit", ldm_out_invbit, e_lb);
    endtask

    // One cycle: check previous results, drive new inputs, update the model.
    task automatic step(bit pv, logic [TW-1:0] pt, logic [1:0] st, bit pl, bit pu,
                        bit pr, bit lv, logic [TW-1:0] lt, string lreq);
        int hit, slot, free;
        bit ins;
        @(negedge clk);
        compare();
        pinv_valid = pv; pinv_tag = pt; line_state = st;
        pend_load = pl; pend_upg = pu; upg_replied = pr;
        ldm_valid = lv; ldm_tag = lt;
        e_rv = pv; e_rt = pt; e_ack = 0; e_keep = 0; e_iv = 0; ins = 0; e_req = "R6";
        if (pv) begin
            if (pl) begin e_keep = 1; e_req = "R1"; end
            else if (pu) begin
                e_ack = !pr && st == 2'b01; e_iv = e_ack; e_req = e_ack ? "R2" : "R3";
            end else if (st == 2'b01) begin
                e_ack = 1; e_iv = 1; ins = 1; e_req = "R4";
            end else e_req = "R5";
        end
        e_it = pt;
        hit = lv ? m_find(lt) : -1;
        e_lv = lv; e_lt = lt; e_lb = (hit >= 0); e_lreq = lreq;
        slot = ins ? m_find(pt) : -1;
        free = -1;
        for (int i = ND - 1; i >= 0; i--) if (!m_vld[i]) free = i;
        if (hit >= 0) m_vld[hit] = 0;
        if (ins) begin
            if (slot < 0 && free >= 0) slot = free;
            else if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % ND; end
            m_vld[slot] = 1; m_tag[slot] = pt;
        end
    endtask

    task automatic idle(); step(0, '0, 2'b00, 0, 0, 0, 0, '0, "R7"); endtask
    task automatic inv(logic [TW-1:0] t, logic [1:0] st, bit pl, bit pu, bit pr);
        step(1, t, st, pl, pu, pr, 0, '0, "R7");
    endtask
    task automatic ld(logic [TW-1:0] t, string r); step(0, '0, 2'b00, 0, 0, 0, 1, t, r); endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();                                     // R11 outputs in reset
        rst_n = 1'b1;
        ld(12'h005, "R11");                            // R11 empty table after reset
        // R4 then R7 hit then R8 removal
        inv(12'h005, 2'b01, 0, 0, 0);
        ld(12'h005, "R7");
        ld(12'h005, "R8");
        // R1 R2 R3 R5 directed; R2 must not insert
        inv(12'h011, 2'b01, 1, 0, 0);
        inv(12'h012, 2'b01, 0, 1, 0);
        ld(12'h012, "R2");
        inv(12'h013, 2'b01, 0, 1, 1);
        inv(12'h014, 2'b10, 0, 1, 0);
        inv(12'h015, 2'b00, 0, 0, 0);
        inv(12'h016, 2'b10, 0, 0, 0);
        inv(12'h017, 2'b11, 0, 0, 0);
        ld(12'h015, "R5");
        // R9 fill eight, ninth replaces entry 0, tenth entry 1
        for (int i = 0; i < 10; i++) inv(TW'(12'h100 + i), 2'b01, 0, 0, 0);
        ld(12'h100, "R9");
        ld(12'h101, "R9");
        ld(12'h102, "R9");
        ld(12'h108, "R9");
        // R10 duplicate insert makes one entry only
        inv(12'h200, 2'b01, 0, 0, 0);
        inv(12'h200, 2'b01, 0, 0, 0);
        ld(12'h200, "R10");
        ld(12'h200, "R10");
        // R10 same-cycle insert and lookup of one present tag
        inv(12'h300, 2'b01, 0, 0, 0);
        step(1, 12'h300, 2'b01, 0, 0, 0, 1, 12'h300, "R10");
        ld(12'h300, "R10");
        // seeded random traffic
        void'($urandom(32'h5eed));
        for (int i = 0; i < 3000; i++) begin
            automatic int r = $urandom;
            step(r[0], TW'(r[7:4]), r[9:8], r[10] & r[11], r[12] & r[13], r[14],
                 r[15], TW'(r[19:16]), "R7");
        end
        idle();
        idle();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule